// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit

This unit sits beside a 32-bit integer pipeline and carries out multiply and divide operations over several clock cycles. The pipeline starts an operation with a one-cycle `start` strobe, an operation code and two operands. The unit then holds `busy` high, and the pipeline treats that as a stall. The product, or the quotient and remainder, lands in a pair of result registers called HI and LO. HI takes the upper product half or the remainder. LO takes the lower product half or the quotient.

Multiply latency depends on how wide the second operand is. A second operand that fits in 16 bits needs one pass through a 33x17 multiplier. A full-width operand needs two passes. Division is bit-serial, with a fixed iteration count regardless of the operands. HI and LO can also be loaded directly from an operand. A read port selects either register. A read request made while an operation is in flight raises `stall` until the result is written.

Top module: `mdu_top`

## Requirements
- R1: Operation codes on `op`: 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 load HI from `opA`, 5 load LO from `opA`. A multiply leaves bits 63..32 of the 64-bit product of `opA` and `opB` in HI and bits 31..0 in LO.
- R2: A multiply is short when bits 31..16 of `opB` are all equal to bit 15 (signed) or all zero (unsigned). A short multiply holds `busy` high for exactly 1 cycle.
- R3: Any other multiply holds `busy` high for exactly 2 cycles.
- R4: A divide holds `busy` high for exactly 33 cycles and then leaves the quotient in LO and the remainder in HI. A signed quotient truncates toward zero, and the remainder carries the sign of the dividend.
- R5: A divide by zero still takes 33 cycles. It leaves LO all ones and HI equal to the dividend.
- R6: Codes 4 and 5 write their register at the clock edge that accepts them, without raising `busy`.
- R7: `rdData` shows HI when `rdSel` is 1 and LO when `rdSel` is 0. `stall` is high exactly when `rdReq` is high while `busy` is high, and is never high while the unit is idle.
- R8: A `start` that arrives while `busy` is high is ignored. `busy` keeps its length, and HI and LO receive only the result of the running operation.
- R9: After reset HI and LO are zero and `busy` is low. Codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation strobe, taken only while idle |
| op | input | 3 | Operation code |
| opA | input | 32 | First operand / dividend / value to load |
| opB | input | 32 | Second operand / divisor |
| rdReq | input | 1 | Pipeline wants to read HI or LO |
| rdSel | input | 1 | Read select: 1 HI, 0 LO |
| busy | output | 1 | Operation in flight; pipeline stall |
| stall | output | 1 | Read request blocked by an operation in flight |
| rdData | output | 32 | Selected result register |

## Verification
The hardest situation to reach from the ports is a second `start` that lands in the middle of a long divide. The stimulus has to strike while `busy` is high, and it has to carry a value that would visibly corrupt HI if it were taken. The driver starts a divide and then, a few cycles later, issues a HI load and a multiply while the divide is still running. The monitor then checks that `busy` lasted exactly 33 cycles and that HI and LO hold only the divide's result. The operand-width boundary is also driven on both sides: a second operand of 0x0000FFFF counts as short for the unsigned multiply but not for the signed one.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam logic [2:0] OP_MULS  = 3'd0;
  localparam logic [2:0] OP_MULU  = 3'd1;
  localparam logic [2:0] OP_DIVS  = 3'd2;
  localparam logic [2:0] OP_DIVU  = 3'd3;
  localparam logic [2:0] OP_SETHI = 3'd4;
  localparam logic [2:0] OP_SETLO = 3'd5;

  typedef struct packed {
    logic load;
    logic mulShort;
    logic mulLow;
    logic mulHigh;
    logic divStep;
    logic divFix;
    logic setHi;
    logic setLo;
  } ctrlStrobes_t;
endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic         bShort,
  output ctrlStrobes_t ctl,
  output logic         busy
);
  localparam int CW = $clog2(W);

  typedef enum logic [2:0] {S_IDLE, S_MULS, S_MUL1, S_MUL2, S_DIV, S_FIX} state_t;

  state_t state, nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          case (op)
            OP_MULS, OP_MULU: begin
              ctl.load = 1'b1;
              nxt = bShort ? S_MULS : S_MUL1;
            end
            OP_DIVS, OP_DIVU: begin
              ctl.load = 1'b1;
              nxt = S_DIV;
            end
            OP_SETHI: ctl.setHi = 1'b1;
            OP_SETLO: ctl.setLo = 1'b1;
            default: ;
          endcase
        end
      end
      S_MULS: begin
        ctl.mulShort = 1'b1;
        nxt = S_IDLE;
      end
      S_MUL1: begin
        ctl.mulLow = 1'b1;
        nxt = S_MUL2;
      end
      S_MUL2: begin
        ctl.mulHigh = 1'b1;
        nxt = S_IDLE;
      end
      S_DIV: begin
        ctl.divStep = 1'b1;
        if (cnt == CW'(W - 1)) nxt = S_FIX;
      end
      S_FIX: begin
        ctl.divFix = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (ctl.load) cnt <= '0;
      else if (ctl.divStep) cnt <= cnt + 1'b1;
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/mdu_dp.sv
module mdu_dp
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t ctl,
  input  logic         signedOp,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         rdSel,
  output logic         bShort,
  output logic [W-1:0] rdData
);
  localparam int HALF = W / 2;
  localparam int PW   = 2 * W;

  logic [W:0]    aX, bX;
  logic [PW-1:0] acc;
  logic [W-1:0]  rem, quo, dvs, hi, lo;
  logic          aNeg, bNeg, bZero;

  // operand width detection on the incoming divisor/multiplier
  always_comb begin
    if (signedOp) bShort = (opB[W-1:HALF] == {(W-HALF){opB[HALF-1]}});
    else          bShort = (opB[W-1:HALF] == '0);
  end

  logic          inANeg, inBNeg;
  logic [W-1:0]  aAbs, bAbs;
  assign inANeg = signedOp & opA[W-1];
  assign inBNeg = signedOp & opB[W-1];
  assign aAbs   = inANeg ? (~opA + 1'b1) : opA;
  assign bAbs   = inBNeg ? (~opB + 1'b1) : opB;

  // multiplier: one (W+1) x (HALF+1) signed pass per cycle
  logic [HALF:0] mOp;
  logic [PW-1:0] aExt, mExt, prodExt, highSum;
  always_comb begin
    if (ctl.mulLow)       mOp = {1'b0, bX[HALF-1:0]};
    else if (ctl.mulHigh) mOp = bX[W:HALF];
    else                  mOp = bX[HALF:0];
  end
  assign aExt    = {{(PW-W-1){aX[W]}}, aX};
  assign mExt    = {{(PW-HALF-1){mOp[HALF]}}, mOp};
  assign prodExt = aExt * mExt;
  assign highSum = acc + (prodExt << HALF);

  // restoring divide step
  logic [W:0]   remSh, diff;
  logic         take;
  logic [W-1:0] remNext, quoNext, qFinal, rFinal;
  assign remSh   = {rem, quo[W-1]};
  assign diff    = remSh - {1'b0, dvs};
  assign take    = ~diff[W];
  assign remNext = take ? diff[W-1:0] : remSh[W-1:0];
  assign quoNext = {quo[W-2:0], take};
  assign qFinal  = bZero ? '1 : ((aNeg ^ bNeg) ? (~quo + 1'b1) : quo);
  assign rFinal  = aNeg ? (~rem + 1'b1) : rem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aX <= '0; bX <= '0; acc <= '0;
      rem <= '0; quo <= '0; dvs <= '0;
      aNeg <= 1'b0; bNeg <= 1'b0; bZero <= 1'b0;
      hi <= '0; lo <= '0;
    end else begin
      if (ctl.load) begin
        aX    <= {signedOp & opA[W-1], opA};
        bX    <= {signedOp & opB[W-1], opB};
        rem   <= '0;
        quo   <= aAbs;
        dvs   <= bAbs;
        aNeg  <= inANeg;
        bNeg  <= inBNeg;
        bZero <= (opB == '0);
      end
      if (ctl.mulLow) acc <= prodExt;
      if (ctl.mulShort) begin
        hi <= prodExt[PW-1:W];
        lo <= prodExt[W-1:0];
      end
      if (ctl.mulHigh) begin
        hi <= highSum[PW-1:W];
        lo <= highSum[W-1:0];
      end
      if (ctl.divStep) begin
        rem <= remNext;
        quo <= quoNext;
      end
      if (ctl.divFix) begin
        hi <= rFinal;
        lo <= qFinal;
      end
      if (ctl.setHi) hi <= opA;
      if (ctl.setLo) lo <= opA;
    end
  end

  assign rdData = rdSel ? hi : lo;
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   op,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         rdReq,
  input  logic         rdSel,
  output logic         busy,
  output logic         stall,
  output logic [W-1:0] rdData
);
  ctrlStrobes_t ctl;
  logic bShort;
  logic signedOp;

  assign signedOp = (op == OP_MULS) || (op == OP_DIVS);

  mdu_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .bShort(bShort), .ctl(ctl), .busy(busy)
  );

  mdu_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .signedOp(signedOp),
    .opA(opA), .opB(opB), .rdSel(rdSel),
    .bShort(bShort), .rdData(rdData)
  );

  assign stall = rdReq & busy;
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [2:0]   op,
  input logic [W-1:0] opB,
  input logic         rdSel,
  input logic         busy,
  input logic         stall,
  input logic [W-1:0] rdData
);
  localparam int HALF = W / 2;

  logic isMul, isDiv, narrow;
  assign isMul  = (op == 3'd0) || (op == 3'd1);
  assign isDiv  = (op == 3'd2) || (op == 3'd3);
  assign narrow = (op == 3'd0) ? (opB[W-1:HALF] == {(W-HALF){opB[HALF-1]}})
                               : (opB[W-1:HALF] == '0);

  // R2
  short_mul_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && isMul && narrow) |=> busy ##1 !busy);

  // R3
  long_mul_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && isMul && !narrow) |=> busy ##1 busy ##1 !busy);

  // R4
  div_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && isDiv) |=> busy);

  // R6
  move_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && (op == 3'd4 || op == 3'd5)) |=> !busy);

  // R7
  idle_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stall);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $stable(rdSel)) |-> $stable(rdData));
endmodule

bind mdu_top mdu_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .op(op), .opB(opB),
  .rdSel(rdSel), .busy(busy), .stall(stall), .rdData(rdData)
);

// File: tb/mdu_top_tb.sv
`timescale 1ns/1ps
module mdu_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        rdReq, rdSel;
  logic        busy, stall;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          cyc;
    logic [31:0] hi;
    logic [31:0] lo;
    string       tag;
  } item_t;
  item_t sbq[$];

  logic [31:0] mHi = '0, mLo = '0;

  always #4 clk = ~clk;

  mdu_top u_dut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .rdReq(rdReq), .rdSel(rdSel), .busy(busy), .stall(stall), .rdData(rdData)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected result model
  task automatic model(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       output int cyc);
    longint sa, sb;
    longint unsigned ua, ub;
    logic [63:0] p;
    int si, sd;
    cyc = 0;
    case (o)
      3'd0: begin
        sa = longint'($signed(a)); sb = longint'($signed(b));
        p = 64'(sa * sb);
        mHi = p[63:32]; mLo = p[31:0];
        cyc = (b[31:16] == {16{b[15]}}) ? 1 : 2;
      end
      3'd1: begin
        ua = {32'd0, a}; ub = {32'd0, b};
        p = ua * ub;
        mHi = p[63:32]; mLo = p[31:0];
        cyc = (b[31:16] == 16'd0) ? 1 : 2;
      end
      3'd2: begin
        cyc = 33;
        if (b == 0) begin mHi = a; mLo = '1; end
        else begin
          si = $signed(a); sd = $signed(b);
          mLo = 32'(si / sd); mHi = 32'(si % sd);
        end
      end
      3'd3: begin
        cyc = 33;
        if (b == 0) begin mHi = a; mLo = '1; end
        else begin mLo = a / b; mHi = a % b; end
      end
      3'd4: mHi = a;
      3'd5: mLo = a;
      default: ;
    endcase
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                       input string tag);
    int cyc;
    item_t it;
    while (sbq.size() != 0 || busy) @(negedge clk);
    @(negedge clk);
    model(o, a, b, cyc);
    it.cyc = cyc; it.hi = mHi; it.lo = mLo; it.tag = tag;
    start = 1'b1; op = o; opA = a; opB = b;
    if (cyc > 0) sbq.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (cyc == 0) sbq.push_back(it);
  endtask

  // monitor: counts busy cycles, probes stall, reads HI/LO on completion
  initial begin
    int cnt;
    item_t it;
    logic [31:0] h, l;
    cnt = 0;
    rdReq = 1'b0; rdSel = 1'b0;
    wait (rstN);
    forever begin
      @(negedge clk);
      if (busy) begin
        if (cnt == 0) begin
          rdReq = 1'b1; #1;
          check(stall === 1'b1, "R7", "stall while busy", 32'(stall), 32'd1);
          rdReq = 1'b0;
        end
        cnt++;
      end else if (sbq.size() > 0 && (cnt > 0 || sbq[0].cyc == 0)) begin
        it = sbq.pop_front();
        check(cnt == it.cyc, it.tag, "busy cycles", 32'(cnt), 32'(it.cyc));
        rdSel = 1'b1; #1; h = rdData;
        rdSel = 1'b0; #1; l = rdData;
        rdReq = 1'b1; #1;
        check(stall === 1'b0, "R7", "stall while idle", 32'(stall), 32'd0);
        rdReq = 1'b0;
        check(h === it.hi, it.tag, "HI", h, it.hi);
        check(l === it.lo, it.tag, "LO", l, it.lo);
        cnt = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    item_t it;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    check(busy === 1'b0, "R9", "busy after reset", 32'(busy), 32'd0);
    it.cyc = 0; it.hi = 0; it.lo = 0; it.tag = "R9";
    sbq.push_back(it);

    issue(3'd0, 32'd123456, 32'hFFFF_FFFB, "R2");   // signed short, negative
    issue(3'd1, 32'hFFFF_FFFF, 32'h0000_FFFF, "R2"); // unsigned short boundary
    issue(3'd0, 32'h7654_3210, 32'h0000_FFFF, "R3"); // signed, not short
    issue(3'd0, 32'hFFFF_FFF9, 32'h1234_5678, "R3"); // R1 signed full
    issue(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3"); // R1 unsigned full
    issue(3'd2, 32'hFFFF_FFEF, 32'd5, "R4");         // -17/5
    issue(3'd2, 32'd17, 32'hFFFF_FFFB, "R4");        // 17/-5
    issue(3'd3, 32'hFFFF_FFF0, 32'd7, "R4");
    issue(3'd2, 32'hFFFF_FFF7, 32'd0, "R5");
    issue(3'd3, 32'h8000_0001, 32'd0, "R5");
    issue(3'd4, 32'hA5A5_0001, 32'd0, "R6");
    issue(3'd5, 32'h5A5A_0002, 32'd0, "R6");
    issue(3'd6, 32'h1111_1111, 32'h2222_2222, "R9");
    issue(3'd7, 32'h3333_3333, 32'h4444_4444, "R9");

    // R8: starts during a running divide are ignored
    issue(3'd3, 32'd1000, 32'd7, "R8");
    repeat (4) @(negedge clk);
    start = 1'b1; op = 3'd4; opA = 32'hDEAD_BEEF;
    @(negedge clk);
    op = 3'd1; opA = 32'd3; opB = 32'd3;
    @(negedge clk);
    start = 1'b0;

    while (sbq.size() != 0 || busy) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule